// File: doc/BRIEF.md
# Lite UART Register Interface

This block is the register file that a bus master sees for a minimal UART. Its four 32-bit word registers hold receive data, transmit data, status and control. Incoming bytes arrive on a byte stream with a valid/ready handshake and are queued in an 8-entry receive FIFO. Bytes written to the transmit register leave at once on a byte stream output. No serial bit timing is modelled, so the transmit side always reports empty.

The block keeps a sticky pending flag. Receive data sets it, and so does any write to the transmit register. A status read clears it once the receive FIFO has been drained. The level interrupt output is the pending flag gated by an enable bit in the control register. The bus is a simple synchronous port with a byte address. Read data is registered and appears one cycle after the request.

Top module: `lite_uart_regs`

## Requirements
- R1: The word index is the byte address shifted right by two. Index 0 is receive data, 1 is transmit data, 2 is status and 3 is control. Read data appears on `bus_rdata_o` in the cycle after the request. An index of 4 or more reads as zero, and a write to such an index changes nothing.
- R2: After reset the FIFO is empty, control is zero, the pending flag is clear, status reads 0x04, `irq_o` is low and `rx_ready_o` is high.
- R3: A byte is taken when `rx_valid_i` and `rx_ready_o` are both high. The FIFO holds 8 bytes. `rx_ready_o` is low while it holds 8, and a byte offered in that state is discarded.
- R4: A read of index 0 returns the oldest queued byte in bits 7:0, with zeros above, and removes it. Bytes come out in arrival order.
- R5: A read of index 0 while the FIFO is empty returns the storage entry at the write position and leaves the count unchanged.
- R6: The status layout is as follows. Bit 0 is set when the FIFO is non-empty. Bit 1 is set when it holds 8. Bit 2 (transmit empty) is always 1. Bit 4 is the pending flag. Bits 3, 5, 6, 7 and 31:8 read 0.
- R7: The pending flag is sticky. It becomes set in any cycle that ends with the FIFO non-empty, and in any cycle that writes index 1.
- R8: A status read clears the pending flag when the FIFO is empty at the time of the read and no byte arrives in the same cycle.
- R9: `irq_o` is high exactly when the pending flag and control bit 4 are both set.
- R10: A control write stores the full 32-bit word, which reads back unchanged. If bit 1 is set, the write empties the FIFO (write position and count go to zero), and a byte offered in the same cycle is discarded. Bit 0 is only stored.
- R11: A write to the status index changes no state.
- R12: A write to index 1 stores the full word, which reads back. In the next cycle it drives `tx_valid_o` high for one cycle, with `tx_data_o` equal to bits 7:0 of the word.
- R13: A receive-data read and an accepted incoming byte in the same cycle leave the count unchanged, and the order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_valid_i | input | 1 | Bus request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| rx_valid_i | input | 1 | Incoming byte valid |
| rx_data_i | input | 8 | Incoming byte |
| rx_ready_o | output | 1 | FIFO can take a byte |
| tx_valid_o | output | 1 | Outgoing byte strobe |
| tx_data_o | output | 8 | Outgoing byte |
| irq_o | output | 1 | Level interrupt |

## Verification
Some properties are checked on every cycle by the assertions:
- The FIFO count never exceeds its depth.
- An accepted byte always leaves the pending flag set.
- Every transmit write yields exactly one strobe, carrying the right byte.
- A status write leaves control untouched.
- A clearing control write empties the FIFO.
- A simultaneous pop and push keeps the count.

Data ordering, the stale read of an empty FIFO, the discarding of a byte offered while full, the exact status words, and the interplay of interrupt enable with the sticky flag across service sequences can be shown only by the bench's directed scenarios.

// File: rtl/lite_uart_pkg.sv
package lite_uart_pkg;
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    IDX_RXD  = 2'd0,
    IDX_TXD  = 2'd1,
    IDX_STAT = 2'd2,
    IDX_CTRL = 2'd3
  } reg_idx_e;

  localparam int ST_RX_NEMPTY = 0;
  localparam int ST_RX_FULL   = 1;
  localparam int ST_TX_EMPTY  = 2;
  localparam int ST_PEND      = 4;

  localparam int CT_RX_CLR = 1;
  localparam int CT_IRQ_EN = 4;

  typedef struct packed {
    logic rd_rx;
    logic rd_any;
    logic wr_tx;
    logic rd_stat;
    logic wr_ctrl;
  } access_t;
endpackage

// File: rtl/lite_uart_decode.sv
module lite_uart_decode
  import lite_uart_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  output access_t           acc_o,
  output logic              in_map_o,
  output reg_idx_e          idx_o
);
  logic [ADDR_W-1:0] word_idx;

  always_comb begin
    word_idx = addr_i >> 2;
    in_map_o = (word_idx < ADDR_W'(4));
    idx_o    = reg_idx_e'(word_idx[1:0]);
    acc_o    = '0;
    if (valid_i && in_map_o) begin
      acc_o.rd_any  = !write_i;
      acc_o.rd_rx   = !write_i && (idx_o == IDX_RXD);
      acc_o.rd_stat = !write_i && (idx_o == IDX_STAT);
      acc_o.wr_tx   =  write_i && (idx_o == IDX_TXD);
      acc_o.wr_ctrl =  write_i && (idx_o == IDX_CTRL);
    end
  end
endmodule

// File: rtl/lite_uart_rx_fifo.sv
module lite_uart_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_valid_i,
  input  logic [W-1:0]     push_data_i,
  output logic             push_ready_o,
  input  logic             pop_i,
  input  logic             clear_i,
  output logic [W-1:0]     head_o,
  output logic [CNT_W-1:0] count_o,
  output logic             nonempty_next_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [CNT_W-1:0] count, count_d;
  logic [PTR_W:0]   base;
  logic [PTR_W-1:0] rd_idx;
  logic             push_ok, pop_ok;

  assign push_ready_o = (count != CNT_W'(DEPTH));
  assign push_ok      = push_valid_i && push_ready_o && !clear_i;
  assign pop_ok       = pop_i && (count != '0) && !clear_i;

  always_comb begin
    base = {1'b0, wr_ptr} + (PTR_W+1)'(DEPTH) - (PTR_W+1)'(count);
    if (base >= (PTR_W+1)'(DEPTH)) base = base - (PTR_W+1)'(DEPTH);
    rd_idx = base[PTR_W-1:0];
  end

  always_comb begin
    if (clear_i) count_d = '0;
    else         count_d = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
  end

  assign head_o          = mem[rd_idx];
  assign count_o         = count;
  assign nonempty_next_o = (count_d != '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    mem[g] <= '0;
      else if (push_ok && (wr_ptr == PTR_W'(g)))      mem[g] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_d;
      if (clear_i)      wr_ptr <= '0;
      else if (push_ok) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/lite_uart_ctrl.sv
module lite_uart_ctrl
  import lite_uart_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  access_t           acc_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              rx_nonempty_i,
  input  logic              rx_nonempty_next_i,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [WORD_W-1:0] txd_o,
  output logic              pend_o,
  output logic              rx_clear_o,
  output logic              tx_valid_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              irq_o
);
  logic [WORD_W-1:0] ctrl_q, txd_q;
  logic              pend_q, pend_d;

  assign rx_clear_o = acc_i.wr_ctrl && wdata_i[CT_RX_CLR];

  always_comb begin
    pend_d = pend_q;
    // serviced only once the FIFO is drained
    if (acc_i.rd_stat && !rx_nonempty_i) pend_d = 1'b0;
    if (rx_nonempty_next_i || acc_i.wr_tx) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      txd_q      <= '0;
      pend_q     <= 1'b0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      pend_q     <= pend_d;
      tx_valid_o <= acc_i.wr_tx;
      if (acc_i.wr_ctrl) ctrl_q <= wdata_i;
      if (acc_i.wr_tx) begin
        txd_q     <= wdata_i;
        tx_data_o <= wdata_i[BYTE_W-1:0];
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign txd_o  = txd_q;
  assign pend_o = pend_q;
  assign irq_o  = pend_q && ctrl_q[CT_IRQ_EN];
endmodule

// File: rtl/lite_uart_regs.sv
module lite_uart_regs
  import lite_uart_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_write_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  output logic              irq_o
);
  access_t           acc;
  logic              in_map;
  reg_idx_e          idx;
  logic [BYTE_W-1:0] head;
  logic [CNT_W-1:0]  count;
  logic              nonempty_next, rx_clear, pend_q;
  logic [WORD_W-1:0] ctrl_q, txd_q, status_w, rdata_q;

  lite_uart_decode #(.ADDR_W(ADDR_W)) u_dec (
    .valid_i (bus_valid_i),
    .write_i (bus_write_i),
    .addr_i  (bus_addr_i),
    .acc_o   (acc),
    .in_map_o(in_map),
    .idx_o   (idx)
  );

  lite_uart_rx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_fifo (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .push_valid_i   (rx_valid_i),
    .push_data_i    (rx_data_i),
    .push_ready_o   (rx_ready_o),
    .pop_i          (acc.rd_rx),
    .clear_i        (rx_clear),
    .head_o         (head),
    .count_o        (count),
    .nonempty_next_o(nonempty_next)
  );

  lite_uart_ctrl u_ctrl (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .acc_i             (acc),
    .wdata_i           (bus_wdata_i),
    .rx_nonempty_i     (count != '0),
    .rx_nonempty_next_i(nonempty_next),
    .ctrl_o            (ctrl_q),
    .txd_o             (txd_q),
    .pend_o            (pend_q),
    .rx_clear_o        (rx_clear),
    .tx_valid_o        (tx_valid_o),
    .tx_data_o         (tx_data_o),
    .irq_o             (irq_o)
  );

  always_comb begin
    status_w               = '0;
    status_w[ST_RX_NEMPTY] = (count != '0);
    status_w[ST_RX_FULL]   = (count == CNT_W'(DEPTH));
    status_w[ST_TX_EMPTY]  = 1'b1;
    status_w[ST_PEND]      = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (bus_valid_i && !bus_write_i) begin
      rdata_q <= '0;
      if (in_map && acc.rd_any) begin
        unique case (idx)
          IDX_RXD:  rdata_q <= {{(WORD_W-BYTE_W){1'b0}}, head};
          IDX_TXD:  rdata_q <= txd_q;
          IDX_STAT: rdata_q <= status_w;
          IDX_CTRL: rdata_q <= ctrl_q;
        endcase
      end
    end
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/lite_uart_chk.sv
module lite_uart_chk #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_valid_i,
  input logic              bus_write_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              tx_valid_o,
  input logic [7:0]        tx_data_o,
  input logic [CNT_W-1:0]  count,
  input logic              pend,
  input logic [31:0]       ctrl
);
  logic [ADDR_W-1:0] widx;
  logic wr, rd, wr_tx, wr_stat, wr_ctrl, rd_rx, clr;

  assign widx    = bus_addr_i >> 2;
  assign wr      = bus_valid_i && bus_write_i;
  assign rd      = bus_valid_i && !bus_write_i;
  assign wr_tx   = wr && (widx == ADDR_W'(1));
  assign wr_stat = wr && (widx == ADDR_W'(2));
  assign wr_ctrl = wr && (widx == ADDR_W'(3));
  assign rd_rx   = rd && (widx == ADDR_W'(0));
  assign clr     = wr_ctrl && bus_wdata_i[1];

  // R3
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH));

  // R7
  rx_sets_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o && !clr) |=> pend);

  // R12
  tx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tx |=> (tx_valid_o && tx_data_o == $past(bus_wdata_i[7:0])));

  // R12
  tx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_tx |=> !tx_valid_o);

  // R11
  stat_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat |=> $stable(ctrl));

  // R10
  rx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (count == '0));

  // R13
  pop_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx && rx_valid_i && rx_ready_o && count != '0) |=> $stable(count));
endmodule

bind lite_uart_regs lite_uart_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_valid_i(bus_valid_i),
  .bus_write_i(bus_write_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .rx_valid_i (rx_valid_i),
  .rx_ready_o (rx_ready_o),
  .tx_valid_o (tx_valid_o),
  .tx_data_o  (tx_data_o),
  .count      (count),
  .pend       (pend_q),
  .ctrl       (ctrl_q)
);

// File: tb/tb_lite_uart_regs.sv
module tb_lite_uart_regs;
  localparam int ADDR_W = 8;
  localparam int DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0, bus_rdata;
  logic              rx_valid = 1'b0, rx_ready;
  logic [7:0]        rx_data = '0;
  logic              tx_valid, irq;
  logic [7:0]        tx_data;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  lite_uart_regs #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .bus_valid_i(bus_valid), .bus_write_i(bus_write), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .irq_o(irq)
  );

  localparam logic [7:0] A_RXD = 8'h00, A_TXD = 8'h04, A_STAT = 8'h08, A_CTRL = 8'h0C;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic cycle(input logic en, input logic wr, input logic [7:0] a,
                       input logic [31:0] wd, input logic push, input logic [7:0] pb,
                       output logic [31:0] rd);
    @(negedge clk);
    bus_valid = en; bus_write = wr; bus_addr = a; bus_wdata = wd;
    rx_valid = push; rx_data = pb;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; rx_valid = 1'b0;
    rd = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] x;
    cycle(1'b1, 1'b1, a, d, 1'b0, 8'h0, x);
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] x;
    cycle(1'b1, 1'b0, a, 32'h0, 1'b0, 8'h0, x);
    chk(req, x, exp);
  endtask

  task automatic push(input logic [7:0] b);
    logic [31:0] x;
    cycle(1'b0, 1'b0, 8'h0, 32'h0, 1'b1, b, x);
  endtask

  task automatic t_reset;
    chk("R2 irq", {31'b0, irq}, 32'h0);
    chk("R2 ready", {31'b0, rx_ready}, 32'h1);
    rd_chk(A_STAT, 32'h04, "R2 status");
    rd_chk(A_CTRL, 32'h0, "R2 ctrl");
  endtask

  task automatic t_map;
    wr(A_CTRL, 32'hA5A5_0010);
    rd_chk(A_CTRL, 32'hA5A5_0010, "R10 ctrl readback");
    wr(8'h10, 32'hFFFF_FFFF);
    rd_chk(8'h10, 32'h0, "R1 idx4 reads 0");
    rd_chk(8'h1C, 32'h0, "R1 idx7 reads 0");
    rd_chk(A_CTRL, 32'hA5A5_0010, "R1 out-of-map write ignored");
    rd_chk(A_STAT, 32'h04, "R1 out-of-map write ignored");
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_tx;
    wr(A_TXD, 32'hDEAD_BE5A);
    chk("R12 tx strobe", {31'b0, tx_valid}, 32'h1);
    chk("R12 tx byte", {24'b0, tx_data}, 32'h5A);
    @(posedge clk); @(negedge clk);
    chk("R12 single pulse", {31'b0, tx_valid}, 32'h0);
    rd_chk(A_TXD, 32'hDEAD_BE5A, "R12 txd readback");
    rd_chk(A_STAT, 32'h14, "R7 tx sets pending");
    rd_chk(A_STAT, 32'h04, "R8 status read clears pending");
  endtask

  task automatic t_rx_order;
    push(8'h11); push(8'h22); push(8'h33);
    rd_chk(A_STAT, 32'h15, "R6 nonempty status");
    rd_chk(A_RXD, 32'h11, "R4 order 0");
    rd_chk(A_RXD, 32'h22, "R4 order 1");
    rd_chk(A_RXD, 32'h33, "R4 order 2");
    rd_chk(A_STAT, 32'h14, "R8 pending kept until empty read");
    rd_chk(A_STAT, 32'h04, "R8 cleared");
  endtask

  task automatic t_full;
    wr(A_CTRL, 32'h2);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R3 ready before full", {31'b0, rx_ready}, 32'h1);
      push(8'h40 + 8'(i));
    end
    chk("R3 ready low when full", {31'b0, rx_ready}, 32'h0);
    push(8'hEE);
    rd_chk(A_STAT, 32'h17, "R6 full status");
    for (int i = 0; i < DEPTH; i++) rd_chk(A_RXD, 32'h40 + i, "R3 R4 full drain, extra byte dropped");
    rd_chk(A_RXD, 32'h40, "R5 stale read of empty FIFO");
    rd_chk(A_STAT, 32'h14, "R5 count unchanged");
    rd_chk(A_STAT, 32'h04, "R8 cleared");
  endtask

  task automatic t_irq;
    wr(A_CTRL, 32'h10);
    chk("R9 irq low, no pending", {31'b0, irq}, 32'h0);
    push(8'h5A);
    chk("R9 irq on rx", {31'b0, irq}, 32'h1);
    rd_chk(A_STAT, 32'h15, "R6 status");
    rd_chk(A_RXD, 32'h5A, "R4 data");
    chk("R7 sticky irq", {31'b0, irq}, 32'h1);
    rd_chk(A_STAT, 32'h14, "R8 status");
    chk("R9 irq cleared", {31'b0, irq}, 32'h0);
    wr(A_TXD, 32'h77);
    chk("R9 irq on tx", {31'b0, irq}, 32'h1);
    wr(A_CTRL, 32'h0);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(A_CTRL, 32'h10);
    chk("R9 irq unmasked", {31'b0, irq}, 32'h1);
    rd_chk(A_STAT, 32'h14, "R8 status");
    chk("R9 irq low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_clear;
    logic [31:0] x;
    push(8'h01); push(8'h02);
    wr(A_CTRL, 32'h12);
    rd_chk(A_CTRL, 32'h12, "R10 ctrl stored");
    rd_chk(A_STAT, 32'h14, "R10 fifo emptied");
    cycle(1'b1, 1'b1, A_CTRL, 32'h2, 1'b1, 8'h99, x);
    rd_chk(A_STAT, 32'h04, "R10 byte with clear dropped");
    rd_chk(A_CTRL, 32'h2, "R10 ctrl stored");
  endtask

  task automatic t_status_wr;
    push(8'h3C);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd_chk(A_CTRL, 32'h2, "R11 ctrl untouched");
    rd_chk(A_STAT, 32'h15, "R11 status untouched");
    rd_chk(A_RXD, 32'h3C, "R11 fifo untouched");
    rd_chk(A_STAT, 32'h14, "R8 status");
  endtask

  task automatic t_simul;
    logic [31:0] x;
    push(8'hA1); push(8'hA2);
    cycle(1'b1, 1'b0, A_RXD, 32'h0, 1'b1, 8'hA3, x);
    chk("R13 pop during push", x, 32'hA1);
    rd_chk(A_STAT, 32'h15, "R13 status");
    rd_chk(A_RXD, 32'hA2, "R13 order");
    rd_chk(A_RXD, 32'hA3, "R13 order");
    rd_chk(A_STAT, 32'h14, "R13 count reached zero");
    rd_chk(A_STAT, 32'h04, "R8 cleared");
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_tx();
    t_rx_order();
    t_full();
    t_irq();
    t_clear();
    t_status_wr();
    t_simul();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule